// File: doc/BRIEF.md
# Multiplexed SAR Converter Sequencer

This block runs an external eight-input, 8-bit successive-approximation converter. The converter has one shared analog multiplexer, a start strobe, an end-of-conversion flag and a three-state output latch that is gated by an output-enable pin. For each conversion the sequencer first places the channel number on three address lines. It then pulses the start strobe and watches the end-of-conversion flag go low and come back high. Only after that does it open the output latch, let the bus settle and register the byte.

Each byte leaves the block on a valid/ready result port, together with the channel it came from. Back-pressure works as follows. While `res_valid` is high and `res_ready` is low, the result and its channel are held unchanged, and no new conversion is started. A beat transfers on any clock edge where both are high. In scan mode the block visits channels 0 to 7 in order and then wraps to 0. In single mode it converts one chosen channel again and again. If the converter stops answering, a timeout sets a sticky error flag and the block goes back to idle and retries.

Top module: `sar_adc_sequencer`

## Requirements
- R1: An active-low asynchronous reset drives `adc_start`, `adc_oe`, `res_valid` and `err_timeout` low and `adc_addr` to 0 at once, without waiting for a clock edge.
- R2: `adc_addr` carries the channel number as a plain binary code. It holds its value for at least one clock before `adc_start` rises and keeps it for every cycle that `adc_start` is high.
- R3: Each conversion uses exactly one `adc_start` pulse, and that pulse is high for exactly START_HI_CYC clock cycles.
- R4: After `adc_start` falls, `adc_oe` is not raised until `adc_eoc` has been seen low and then high. An `adc_eoc` that is still high from the previous conversion is ignored.
- R5: `adc_oe` stays high for SETTLE_CYC+1 cycles. `adc_data` is registered in the last of those cycles. `adc_oe` and `adc_start` are never high together.
- R6: Each result presents the registered bus byte on `res_data` and the converted channel number on `res_chan`.
- R7: With `scan_en`=1, successive results come from channels 0,1,...,7,0,1,... counting from reset.
- R8: With `scan_en`=0, every conversion uses the channel on `fix_chan`.
- R9: While `res_valid`=1 and `res_ready`=0, `res_data` and `res_chan` stay stable and no new `adc_start` pulse is issued.
- R10: If `adc_eoc` does not go low within TIMEOUT_CYC cycles after the start pulse, or does not go high within TIMEOUT_CYC cycles after going low, then `err_timeout` is set, no result is produced and the block retries. `err_timeout` stays set until reset.
- R11: While `run_en`=0, no new conversion is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Allows new conversions to start |
| scan_en | input | 1 | 1: scan all channels in turn, 0: convert `fix_chan` only |
| fix_chan | input | 3 | Channel used in single mode |
| adc_addr | output | 3 | Channel address to the converter multiplexer |
| adc_start | output | 1 | Start strobe to the converter |
| adc_eoc | input | 1 | End-of-conversion flag (low while converting) |
| adc_oe | output | 1 | Output enable for the converter's three-state latch |
| adc_data | input | 8 | Converter data bus |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by the consumer |
| res_chan | output | 3 | Channel that produced the result |
| res_data | output | 8 | Converted byte |
| err_timeout | output | 1 | Sticky error: the converter did not answer in time |

## Verification
A behavioural converter model drives the bus with the address in the top three bits and a per-test tag in the low five bits. This lets each result show both the channel that was converted and the fact that the byte was taken from the bus. In scan runs the model is used to check the wrap order. In single runs it confirms that `fix_chan` is honoured and that there is one start pulse per result. Every conversion leaves `adc_eoc` high for a few cycles after the start pulse falls, so a sequencer that trusts a stale flag opens the latch too early. A stalled consumer shows whether the output is held and whether start pulses are suppressed. A flag stuck high and a flag stuck low exercise the two timeout paths separately, and the stuck-low run then recovers to show that the error stays set.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_SET_ADDR,
    S_START_HI,
    S_START_LO,
    S_WAIT_LO,
    S_WAIT_HI,
    S_OE,
    S_CAPTURE,
    S_NEXT
  } seq_state_t;
endpackage

// File: rtl/sar_chan_pick.sv
module sar_chan_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            scan_en,
  input  logic [CH_W-1:0] fix_chan,
  output logic [CH_W-1:0] pick
);
  logic [CH_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == CH_W'(NUM_CH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign pick = scan_en ? ptr_q : fix_chan;

  // R7: the scan pointer only ever steps by one, or wraps to 0
  assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q == $past(ptr_q) + 1'b1) || (ptr_q == '0));
endmodule

// File: rtl/sar_cyc_timer.sv
module sar_cyc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (cnt != {W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int DATA_W       = 8,
  parameter int START_HI_CYC = 2,
  parameter int SETTLE_CYC   = 2,
  parameter int TIMEOUT_CYC  = 4096,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int MAX_CYC = (TIMEOUT_CYC > START_HI_CYC) ?
                           ((TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC) :
                           ((START_HI_CYC > SETTLE_CYC) ? START_HI_CYC : SETTLE_CYC),
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              scan_en,
  input  logic [CH_W-1:0]   fix_chan,
  output logic [CH_W-1:0]   adc_addr,
  output logic              adc_start,
  input  logic              adc_eoc,
  output logic              adc_oe,
  input  logic [DATA_W-1:0] adc_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CH_W-1:0]   res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              err_timeout
);
  seq_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  pick;
  logic             scan_q;
  logic             stalled, tmo_hit, tmo_fire, adv;

  assign stalled  = res_valid && !res_ready;
  assign tmo_hit  = (cnt == CNT_W'(TIMEOUT_CYC - 1));
  assign tmo_fire = tmo_hit && (((state_q == S_WAIT_LO) && adc_eoc) ||
                                ((state_q == S_WAIT_HI) && !adc_eoc));
  assign adv      = (state_q == S_NEXT) && scan_q;

  sar_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk(clk), .rst_n(rst_n), .adv(adv), .scan_en(scan_en),
    .fix_chan(fix_chan), .pick(pick)
  );

  sar_cyc_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .cnt(cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (run_en && !stalled) state_d = S_SET_ADDR;
      S_SET_ADDR: state_d = S_START_HI;
      S_START_HI: if (cnt == CNT_W'(START_HI_CYC - 1)) state_d = S_START_LO;
      S_START_LO: state_d = S_WAIT_LO;
      S_WAIT_LO:  if (!adc_eoc) state_d = S_WAIT_HI;
                  else if (tmo_hit) state_d = S_IDLE;
      S_WAIT_HI:  if (adc_eoc) state_d = S_OE;
                  else if (tmo_hit) state_d = S_IDLE;
      S_OE:       if (cnt == CNT_W'(SETTLE_CYC - 1)) state_d = S_CAPTURE;
      S_CAPTURE:  state_d = S_NEXT;
      S_NEXT:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      adc_start   <= 1'b0;
      adc_oe      <= 1'b0;
      adc_addr    <= '0;
      scan_q      <= 1'b0;
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_data    <= '0;
      err_timeout <= 1'b0;
    end else begin
      state_q   <= state_d;
      adc_start <= (state_d == S_START_HI);
      adc_oe    <= (state_d == S_OE) || (state_d == S_CAPTURE);
      if ((state_q == S_IDLE) && (state_d == S_SET_ADDR)) begin
        adc_addr <= pick;
        scan_q   <= scan_en;
      end
      if (state_q == S_CAPTURE) begin
        res_data  <= adc_data;
        res_chan  <= adc_addr;
        res_valid <= 1'b1;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
      if (tmo_fire) err_timeout <= 1'b1;
    end
  end

  // R2: the address is settled before the strobe rises and held while it is high
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $stable(adc_addr));
  // R5: output enable and start never overlap
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_start && adc_oe));
  // R4: output enable only opens after end of conversion was seen high
  assert_oe_after_eoc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_oe) |-> $past(adc_eoc));
  // R9: a stalled result is held
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> res_valid && $stable(res_data) && $stable(res_chan));
  // R9: no start pulse begins while the output is stalled
  assert_no_start_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> !$rose(adc_start));
  // R10: the error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout);
endmodule

// File: tb/sar_adc_sequencer_bench.sv
`timescale 1ns/1ps
module sar_adc_sequencer_bench;
  localparam int START_HI = 2;
  localparam int SETTLE   = 2;
  localparam int TMO      = 40;
  localparam int STALE    = 3;
  localparam int CONV     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, scan_en = 1'b0, res_ready = 1'b0;
  logic [2:0] fix_chan = 3'd0;
  logic [2:0] adc_addr, res_chan;
  logic adc_start, adc_oe, res_valid, err_timeout;
  logic adc_eoc;
  logic [7:0] adc_data, res_data;
  logic [4:0] salt = 5'd0;
  int m_mode = 0; // 0 normal, 1 flag stuck high, 2 flag stuck low

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign adc_data = adc_oe ? {adc_addr, salt} : 8'hzz;

  sar_adc_sequencer #(.START_HI_CYC(START_HI), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO))
  u_sar_adc_sequencer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .scan_en(scan_en), .fix_chan(fix_chan),
    .adc_addr(adc_addr), .adc_start(adc_start), .adc_eoc(adc_eoc), .adc_oe(adc_oe),
    .adc_data(adc_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .err_timeout(err_timeout)
  );

  // converter model
  int m_ph = 0, m_cnt = 0;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; adc_eoc <= 1'b1;
    end else begin
      case (m_ph)
        0: if (adc_start) m_ph <= 1;
        1: if (!adc_start) begin m_ph <= 2; m_cnt <= 0; end
        2: if (m_mode == 1) m_ph <= 0;
           else if (m_cnt == STALE - 1) begin adc_eoc <= 1'b0; m_cnt <= 0; m_ph <= 3; end
           else m_cnt <= m_cnt + 1;
        default:
           if (m_mode == 2) begin if (adc_start) m_ph <= 1; end
           else if (m_cnt == CONV - 1) begin adc_eoc <= 1'b1; m_ph <= 0; end
           else m_cnt <= m_cnt + 1;
      endcase
    end
  end

  // protocol monitors and result collector
  logic p_start = 0, p_oe = 0, seen_low = 0;
  logic [2:0] p_addr = 0, rise_addr = 0;
  int st_run = 0, oe_run = 0;
  int st_rises = 0, oe_rises = 0, v_addr = 0, v_start = 0, v_oe = 0, v_guard = 0, v_excl = 0;
  int n_got = 0;
  logic [2:0] got_ch [0:255];
  logic [7:0] got_d  [0:255];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_start = 0; p_oe = 0; p_addr = 0; st_run = 0; oe_run = 0;
    end else begin
      if (adc_start && !p_start) begin
        st_rises++; if (adc_addr != p_addr) v_addr++;
        rise_addr = adc_addr; st_run = 1; seen_low = 0;
      end else if (adc_start) begin
        st_run++; if (adc_addr != rise_addr) v_addr++;
      end else if (p_start && st_run != START_HI) v_start++;
      if (!adc_start && !adc_eoc) seen_low = 1;
      if (adc_oe && !p_oe) begin
        oe_rises++; if (!seen_low) v_guard++; oe_run = 1;
      end else if (adc_oe) oe_run++;
      else if (p_oe && oe_run != SETTLE + 1) v_oe++;
      if (adc_oe && adc_start) v_excl++;
      if (res_valid && res_ready) begin
        got_ch[n_got[7:0]] = res_chan; got_d[n_got[7:0]] = res_data; n_got++;
      end
      p_start = adc_start; p_oe = adc_oe; p_addr = adc_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run_en = 1'b0; res_ready = 1'b0; m_mode = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_got(input int target, input int max_cyc);
    for (int i = 0; i < max_cyc && n_got < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    scan_en = 1'b1; res_ready = 1'b1; run_en = 1'b1;
    repeat (9) @(negedge clk); // mid start/wait phase
    rst_n = 1'b0; #1;
    chk(adc_start == 0, "R1 start", adc_start, 0);
    chk(adc_oe == 0, "R1 oe", adc_oe, 0);
    chk(adc_addr == 0, "R1 addr", adc_addr, 0);
    chk(res_valid == 0, "R1 valid", res_valid, 0);
    chk(err_timeout == 0, "R1 err", err_timeout, 0);
  endtask

  task automatic t_scan();
    int b, vs, vo, vg, va, vx;
    do_reset();
    salt = 5'h15; scan_en = 1'b1; res_ready = 1'b1;
    b = n_got; vs = v_start; vo = v_oe; vg = v_guard; va = v_addr; vx = v_excl;
    run_en = 1'b1;
    wait_got(b + 10, 2000);
    run_en = 1'b0;
    chk(n_got - b >= 10, "R7 count", n_got - b, 10);
    for (int i = 0; i < 10; i++) begin
      chk(got_ch[(b + i) % 256] == 3'(i % 8), "R7 order", got_ch[(b + i) % 256], i % 8);
      chk(got_d[(b + i) % 256] == {3'(i % 8), salt}, "R6 data", got_d[(b + i) % 256], {3'(i % 8), salt});
    end
    chk(v_addr == va, "R2 addr hold", v_addr - va, 0);
    chk(v_start == vs, "R3 start width", v_start - vs, 0);
    chk(v_guard == vg, "R4 stale eoc", v_guard - vg, 0);
    chk(v_oe == vo, "R5 oe width", v_oe - vo, 0);
    chk(v_excl == vx, "R5 overlap", v_excl - vx, 0);
  endtask

  task automatic t_single();
    int b, s0, d;
    do_reset();
    salt = 5'h0a; scan_en = 1'b0; fix_chan = 3'd5; res_ready = 1'b1;
    b = n_got; s0 = st_rises;
    run_en = 1'b1;
    wait_got(b + 3, 1000);
    run_en = 1'b0;
    d = (st_rises - s0) - (n_got - b);
    chk(d == 0 || d == 1, "R3 one pulse per result", d, 0);
    for (int i = 0; i < 3; i++) begin
      chk(got_ch[(b + i) % 256] == 3'd5, "R8 channel", got_ch[(b + i) % 256], 5);
      chk(got_d[(b + i) % 256] == {3'd5, salt}, "R6 data", got_d[(b + i) % 256], {3'd5, salt});
    end
  endtask

  task automatic t_stall();
    logic [7:0] d0; logic [2:0] c0; int s0, b;
    do_reset();
    salt = 5'h1c; scan_en = 1'b0; fix_chan = 3'd3; res_ready = 1'b0;
    run_en = 1'b1;
    for (int i = 0; i < 500 && !res_valid; i++) @(negedge clk);
    d0 = res_data; c0 = res_chan; s0 = st_rises;
    repeat (100) @(negedge clk);
    chk(res_valid == 1, "R9 valid held", res_valid, 1);
    chk(res_data == d0 && d0 == {3'd3, salt}, "R9 data held", res_data, {3'd3, salt});
    chk(res_chan == c0 && c0 == 3'd3, "R9 chan held", res_chan, 3);
    chk(st_rises == s0, "R9 no start while stalled", st_rises - s0, 0);
    b = n_got;
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 0, "R9 released", res_valid, 0);
    chk(n_got == b + 1, "R9 one transfer", n_got - b, 1);
    run_en = 1'b0;
  endtask

  task automatic t_tmo_high();
    int o0, s0, b;
    do_reset();
    m_mode = 1; scan_en = 1'b0; fix_chan = 3'd2; res_ready = 1'b1;
    o0 = oe_rises; s0 = st_rises; b = n_got;
    run_en = 1'b1;
    repeat (TMO / 2) @(negedge clk);
    chk(err_timeout == 0, "R10 not early", err_timeout, 0);
    repeat (3 * TMO) @(negedge clk);
    run_en = 1'b0;
    chk(err_timeout == 1, "R10 stuck high", err_timeout, 1);
    chk(oe_rises == o0, "R10 no oe", oe_rises - o0, 0);
    chk(n_got == b, "R10 no result", n_got - b, 0);
    chk(st_rises - s0 >= 2, "R10 retry", st_rises - s0, 2);
  endtask

  task automatic t_tmo_low();
    int b;
    do_reset();
    m_mode = 2; salt = 5'h07; scan_en = 1'b0; fix_chan = 3'd6; res_ready = 1'b1;
    b = n_got;
    run_en = 1'b1;
    repeat (3 * TMO) @(negedge clk);
    chk(err_timeout == 1, "R10 stuck low", err_timeout, 1);
    chk(n_got == b, "R10 no result", n_got - b, 0);
    m_mode = 0;
    wait_got(b + 2, 1000);
    run_en = 1'b0;
    chk(n_got - b >= 2, "R10 recovers", n_got - b, 2);
    chk(got_d[b % 256] == {3'd6, salt}, "R10 data after recovery", got_d[b % 256], {3'd6, salt});
    chk(err_timeout == 1, "R10 sticky", err_timeout, 1);
  endtask

  task automatic t_run_off();
    int s0;
    do_reset();
    scan_en = 1'b1; res_ready = 1'b1; run_en = 1'b0;
    s0 = st_rises;
    repeat (100) @(negedge clk);
    chk(st_rises == s0, "R11 idle when disabled", st_rises - s0, 0);
    chk(adc_start == 0 && adc_oe == 0, "R11 pins quiet", adc_start + adc_oe, 0);
  endtask

  initial begin
    t_reset();
    t_scan();
    t_single();
    t_stall();
    t_tmo_high();
    t_tmo_low();
    t_run_off();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule